// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a small data cache for one processor port. The main array is direct-mapped and indexed by a slice of the line address. Next to it sits a small fully associative side store. That store holds the lines recently pushed out of the main array, so two or three lines that keep evicting each other from one set can still be reached without going to memory. Every access probes both structures in the same cycle.

When the requested line is in the main array, the access completes at once. When the main array misses but the side store holds the line, the two lines trade places: the requested line returns to its set, and the previous occupant of that set takes its slot in the side store. When both structures miss, the block asks the memory side for the whole line. The refilled line goes into the main array, and the line it displaces is pushed into the side store, which gives up its least recently used entry. If that entry was modified, it is first written back to memory.

Reads and writes share one request/response port and are handled one at a time. The memory port carries line-sized reads and writebacks, and read data comes back on a separate fill channel.

Top module: `cvb_cache`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: An access whose line is in the main array gets its response two clock edges after the edge that accepted it, with `rsp_hit_main`=1 and `rsp_hit_victim`=0. It issues no memory read.
- R3: An access that misses both structures issues exactly one memory read (`mem_req_write`=0) carrying the line address, which is the request address without its low log2(LINE_WORDS) bits. The response follows the fill, with both status bits 0, and the refilled line then hits in the main array.
- R4: A valid line displaced from the main array by a refill is placed in the side store and is not discarded.
- R5: A side-store hit swaps the requested line with the main-array occupant of its set. The response comes one edge later than a main-array hit, with `rsp_hit_victim`=1 and `rsp_hit_main`=0. The displaced line can then be found in the side store.
- R6: A line entering the side store takes a free slot if there is one. Otherwise it replaces the least recently used entry, where an entry counts as used when it is written.
- R7: When a modified line leaves the side store, its whole line is written to memory (`mem_req_write`=1) at its line address before the read for the new line. A clean line leaves without any memory traffic. A memory request holds its address until it is accepted.
- R8: A write updates the addressed word in place, allocates the line on a miss, and marks the line modified. The modified mark travels with the line through swaps and evictions. The response data of a write is the written word.
- R9: Only one access is in flight: `req_ready` is 0 from the cycle after acceptance until the response, and `rsp_valid` is a one-cycle pulse.
- R10: A line is held in at most one place: never in both structures, and never in two side-store entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read word, or the written word for a write |
| rsp_hit_main | output | 1 | Access hit in the main array |
| rsp_hit_victim | output | 1 | Access hit in the side store |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = writeback of a line, 0 = line read |
| mem_req_laddr | output | ADDR_W-log2(LINE_WORDS) | Line address |
| mem_req_wline | output | DATA_W*LINE_WORDS | Writeback line data |
| mem_fill_valid | input | 1 | Fill data for the outstanding read |
| mem_fill_line | input | DATA_W*LINE_WORDS | Fill line data |

## Verification
Some properties are checked on every cycle by assertions: that no line appears in both structures or twice in the side store, that the side store always has exactly one oldest entry, the response latency for each hit kind, the busy window, and that memory requests hold steady until accepted. What the assertions cannot show is where data actually ends up. Only the directed scenarios reveal whether a swapped line returns with the right contents, whether the least recently used entry is the one that leaves, and whether a written word survives a swap, an eviction and a later refill from memory.

// File: rtl/cvb_pkg.sv
package cvb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_SWAP,
        ST_WBACK,
        ST_READ,
        ST_FILL
    } ctl_state_e;

endpackage

// File: rtl/cvb_lru.sv
module cvb_lru #(
    parameter int ENTRIES = 2,
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] oldest_idx
);

    // ages form a permutation of 0..ENTRIES-1; 0 = most recent
    localparam int AW = IW;

    typedef struct packed {
        logic [ENTRIES-1:0][AW-1:0] age;
    } lru_t;

    lru_t lru_d, lru_q;
    logic [ENTRIES-1:0] old_vec;

    always_comb begin
        lru_d      = lru_q;
        oldest_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            old_vec[i] = (lru_q.age[i] == AW'(ENTRIES - 1));
            if (old_vec[i]) oldest_idx = IW'(i);
        end
        if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (i == int'(touch_idx)) begin
                    lru_d.age[i] = '0;
                end else if (lru_q.age[i] < lru_q.age[touch_idx]) begin
                    lru_d.age[i] = lru_q.age[i] + AW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) lru_q.age[i] <= AW'(i);
        end else begin
            lru_q <= lru_d;
        end
    end

    AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(old_vec)); // R6

endmodule

// File: rtl/cvb_main_array.sv
module cvb_main_array #(
    parameter int SETS   = 8,
    parameter int TAG_W  = 11,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);

    typedef struct packed {
        logic              v;
        logic              d;
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] data;
    } mline_t;

    typedef struct packed {
        mline_t [SETS-1:0] set;
    } marr_t;

    marr_t arr_d, arr_q;

    always_comb begin
        arr_d    = arr_q;
        rd_valid = arr_q.set[rd_idx].v;
        rd_dirty = arr_q.set[rd_idx].d;
        rd_tag   = arr_q.set[rd_idx].tag;
        rd_line  = arr_q.set[rd_idx].data;
        if (wr_en) begin
            arr_d.set[wr_idx].v    = 1'b1;
            arr_d.set[wr_idx].d    = wr_dirty;
            arr_d.set[wr_idx].tag  = wr_tag;
            arr_d.set[wr_idx].data = wr_line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arr_q <= '0;
        else        arr_q <= arr_d;
    end

endmodule

// File: rtl/cvb_victim_buf.sv
module cvb_victim_buf #(
    parameter int ENTRIES = 2,
    parameter int LADDR_W = 14,
    parameter int LINE_W  = 128,
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LADDR_W-1:0] lk_laddr,
    output logic               lk_hit,
    output logic [IW-1:0]      lk_idx,
    output logic               lk_dirty,
    output logic [LINE_W-1:0]  lk_line,
    output logic [IW-1:0]      sel_idx,
    output logic               sel_valid,
    output logic               sel_dirty,
    output logic [LADDR_W-1:0] sel_laddr,
    output logic [LINE_W-1:0]  sel_line,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic               wr_valid,
    input  logic               wr_dirty,
    input  logic [LADDR_W-1:0] wr_laddr,
    input  logic [LINE_W-1:0]  wr_line
);

    typedef struct packed {
        logic               v;
        logic               d;
        logic [LADDR_W-1:0] laddr;
        logic [LINE_W-1:0]  data;
    } vent_t;

    typedef struct packed {
        vent_t [ENTRIES-1:0] ent;
    } vbuf_t;

    vbuf_t vb_d, vb_q;

    logic [ENTRIES-1:0] hit_vec;
    logic               have_free;
    logic [IW-1:0]      free_idx;
    logic [IW-1:0]      oldest_idx;

    cvb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (wr_en && wr_valid),
        .touch_idx  (wr_idx),
        .oldest_idx (oldest_idx)
    );

    always_comb begin
        vb_d      = vb_q;
        lk_idx    = '0;
        have_free = 1'b0;
        free_idx  = '0;
        // full line address compare: the store has no index field
        for (int i = 0; i < ENTRIES; i++) begin
            hit_vec[i] = vb_q.ent[i].v && (vb_q.ent[i].laddr == lk_laddr);
            if (hit_vec[i]) lk_idx = IW'(i);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vb_q.ent[i].v) begin
                have_free = 1'b1;
                free_idx  = IW'(i);
            end
        end
        lk_hit    = |hit_vec;
        lk_dirty  = vb_q.ent[lk_idx].d;
        lk_line   = vb_q.ent[lk_idx].data;
        sel_idx   = have_free ? free_idx : oldest_idx;
        sel_valid = vb_q.ent[sel_idx].v;
        sel_dirty = vb_q.ent[sel_idx].d;
        sel_laddr = vb_q.ent[sel_idx].laddr;
        sel_line  = vb_q.ent[sel_idx].data;
        if (wr_en) begin
            vb_d.ent[wr_idx].v     = wr_valid;
            vb_d.ent[wr_idx].d     = wr_valid && wr_dirty;
            vb_d.ent[wr_idx].laddr = wr_laddr;
            vb_d.ent[wr_idx].data  = wr_line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vb_q <= '0;
        else        vb_q <= vb_d;
    end

    AST_VB_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R10

endmodule

// File: rtl/cvb_cache.sv
module cvb_cache
    import cvb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 8,
    parameter int VB_ENTRIES = 2,
    localparam int OFF_W   = $clog2(LINE_WORDS),
    localparam int LADDR_W = ADDR_W - OFF_W,
    localparam int LINE_W  = DATA_W * LINE_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_hit_main,
    output logic               rsp_hit_victim,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_write,
    output logic [LADDR_W-1:0] mem_req_laddr,
    output logic [LINE_W-1:0]  mem_req_wline,
    input  logic               mem_fill_valid,
    input  logic [LINE_W-1:0]  mem_fill_line
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = LADDR_W - IDX_W;
    localparam int VB_IW = (VB_ENTRIES > 1) ? $clog2(VB_ENTRIES) : 1;

    typedef struct packed {
        ctl_state_e        st;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
        logic              rsp_m;
        logic              rsp_vh;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [OFF_W-1:0]   off;
    logic [IDX_W-1:0]   idx;
    logic [TAG_W-1:0]   tag;
    logic [LADDR_W-1:0] laddr;

    logic               m_v, m_d;
    logic [TAG_W-1:0]   m_tag;
    logic [LINE_W-1:0]  m_line;
    logic               m_wr_en, m_wr_dirty;
    logic [LINE_W-1:0]  m_wr_line;

    logic               v_hit, v_d;
    logic [VB_IW-1:0]   v_idx;
    logic [LINE_W-1:0]  v_line;
    logic [VB_IW-1:0]   s_idx;
    logic               s_v, s_d;
    logic [LADDR_W-1:0] s_laddr;
    logic [LINE_W-1:0]  s_line;
    logic               vb_wr_en, vb_wr_valid, vb_wr_dirty;
    logic [VB_IW-1:0]   vb_wr_idx;
    logic [LADDR_W-1:0] vb_wr_laddr;
    logic [LINE_W-1:0]  vb_wr_line;

    logic               main_hit;
    logic [LINE_W-1:0]  base_line, new_line;
    logic [DATA_W-1:0]  new_word;

    assign off   = ctl_q.addr[OFF_W-1:0];
    assign idx   = ctl_q.addr[OFF_W +: IDX_W];
    assign tag   = ctl_q.addr[ADDR_W-1 -: TAG_W];
    assign laddr = ctl_q.addr[ADDR_W-1:OFF_W];

    cvb_main_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx),
        .rd_valid (m_v),
        .rd_dirty (m_d),
        .rd_tag   (m_tag),
        .rd_line  (m_line),
        .wr_en    (m_wr_en),
        .wr_idx   (idx),
        .wr_dirty (m_wr_dirty),
        .wr_tag   (tag),
        .wr_line  (m_wr_line)
    );

    cvb_victim_buf #(.ENTRIES(VB_ENTRIES), .LADDR_W(LADDR_W), .LINE_W(LINE_W)) u_vb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_laddr  (laddr),
        .lk_hit    (v_hit),
        .lk_idx    (v_idx),
        .lk_dirty  (v_d),
        .lk_line   (v_line),
        .sel_idx   (s_idx),
        .sel_valid (s_v),
        .sel_dirty (s_d),
        .sel_laddr (s_laddr),
        .sel_line  (s_line),
        .wr_en     (vb_wr_en),
        .wr_idx    (vb_wr_idx),
        .wr_valid  (vb_wr_valid),
        .wr_dirty  (vb_wr_dirty),
        .wr_laddr  (vb_wr_laddr),
        .wr_line   (vb_wr_line)
    );

    assign main_hit = m_v && (m_tag == tag);

    // line the access lands on, with the write word merged in
    always_comb begin
        case (ctl_q.st)
            ST_SWAP: base_line = v_line;
            ST_FILL: base_line = mem_fill_line;
            default: base_line = m_line;
        endcase
        for (int w = 0; w < LINE_WORDS; w++) begin
            new_line[w*DATA_W +: DATA_W] = (ctl_q.wr && (w == int'(off)))
                                         ? ctl_q.wdata
                                         : base_line[w*DATA_W +: DATA_W];
        end
        new_word = new_line[int'(off)*DATA_W +: DATA_W];
    end

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.rsp_v   = 1'b0;
        req_ready     = (ctl_q.st == ST_IDLE);
        m_wr_en       = 1'b0;
        m_wr_dirty    = 1'b0;
        m_wr_line     = new_line;
        vb_wr_en      = 1'b0;
        vb_wr_idx     = s_idx;
        vb_wr_valid   = m_v;
        vb_wr_dirty   = m_d;
        vb_wr_laddr   = {m_tag, idx};
        vb_wr_line    = m_line;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_laddr = laddr;
        mem_req_wline = '0;

        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st    = ST_LOOK;
                    ctl_d.wr    = req_write;
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                end
            end
            ST_LOOK: begin
                if (main_hit) begin
                    m_wr_en      = ctl_q.wr;
                    m_wr_dirty   = 1'b1;
                    ctl_d.rsp_v  = 1'b1;
                    ctl_d.rsp_d  = new_word;
                    ctl_d.rsp_m  = 1'b1;
                    ctl_d.rsp_vh = 1'b0;
                    ctl_d.st     = ST_IDLE;
                end else if (v_hit) begin
                    ctl_d.st = ST_SWAP;
                end else if (m_v && s_v && s_d) begin
                    ctl_d.st = ST_WBACK;
                end else begin
                    ctl_d.st = ST_READ;
                end
            end
            ST_SWAP: begin
                m_wr_en      = 1'b1;
                m_wr_dirty   = v_d || ctl_q.wr;
                vb_wr_en     = 1'b1;
                vb_wr_idx    = v_idx;
                ctl_d.rsp_v  = 1'b1;
                ctl_d.rsp_d  = new_word;
                ctl_d.rsp_m  = 1'b0;
                ctl_d.rsp_vh = 1'b1;
                ctl_d.st     = ST_IDLE;
            end
            ST_WBACK: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_laddr = s_laddr;
                mem_req_wline = s_line;
                if (mem_req_ready) ctl_d.st = ST_READ;
            end
            ST_READ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) ctl_d.st = ST_FILL;
            end
            ST_FILL: begin
                if (mem_fill_valid) begin
                    m_wr_en      = 1'b1;
                    m_wr_dirty   = ctl_q.wr;
                    vb_wr_en     = m_v;
                    ctl_d.rsp_v  = 1'b1;
                    ctl_d.rsp_d  = new_word;
                    ctl_d.rsp_m  = 1'b0;
                    ctl_d.rsp_vh = 1'b0;
                    ctl_d.st     = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid      = ctl_q.rsp_v;
    assign rsp_rdata      = ctl_q.rsp_d;
    assign rsp_hit_main   = ctl_q.rsp_m;
    assign rsp_hit_victim = ctl_q.rsp_vh;

    AST_MAIN_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit_main) |-> $past(req_valid && req_ready, 2)); // R2

    AST_SWAP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit_victim) |-> $past(req_valid && req_ready, 3)); // R5

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_hit_main && rsp_hit_victim)); // R5

    AST_SINGLE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_LOOK) |-> !(main_hit && v_hit)); // R10

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R9

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9

    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_laddr) && $stable(mem_req_write))); // R7

endmodule

// File: tb/tb_cvb_cache.sv
module tb_cvb_cache;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int LW     = 4;
    localparam int LAW    = 14;
    localparam int LINE_W = DATA_W * LW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_hit_main, rsp_hit_victim;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b1;
    logic              mem_req_write;
    logic [LAW-1:0]    mem_req_laddr;
    logic [LINE_W-1:0] mem_req_wline;
    logic              mem_fill_valid = 1'b0;
    logic [LINE_W-1:0] mem_fill_line = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cvb_cache dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_hit_main(rsp_hit_main), .rsp_hit_victim(rsp_hit_victim),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_laddr(mem_req_laddr),
        .mem_req_wline(mem_req_wline),
        .mem_fill_valid(mem_fill_valid), .mem_fill_line(mem_fill_line)
    );

    // ---------------- memory model ----------------
    logic [LINE_W-1:0] mem [int];
    int                rd_count = 0, wb_count = 0, ev = 0, rd_seq = 0, wb_seq = 0;
    int                fill_cnt = 0;
    logic [LAW-1:0]    last_rd = '0, last_wb = '0, pend = '0;
    logic [LINE_W-1:0] last_wb_line = '0;

    function automatic logic [DATA_W-1:0] pat(input int la, input int w);
        return 32'h5000_0000 + 32'(la * 16 + w);
    endfunction

    function automatic logic [LINE_W-1:0] line_of(input logic [LAW-1:0] la);
        logic [LINE_W-1:0] l;
        if (mem.exists(int'(la))) return mem[int'(la)];
        for (int w = 0; w < LW; w++) l[w*DATA_W +: DATA_W] = pat(int'(la), w);
        return l;
    endfunction

    always @(negedge clk) begin
        mem_fill_valid <= 1'b0;
        if (fill_cnt > 0) begin
            fill_cnt = fill_cnt - 1;
            if (fill_cnt == 0) begin
                mem_fill_valid <= 1'b1;
                mem_fill_line  <= line_of(pend);
            end
        end
        if (rst_n && mem_req_valid) begin
            ev = ev + 1;
            if (mem_req_write) begin
                mem[int'(mem_req_laddr)] = mem_req_wline;
                wb_count = wb_count + 1;
                wb_seq = ev;
                last_wb = mem_req_laddr;
                last_wb_line = mem_req_wline;
            end else begin
                rd_count = rd_count + 1;
                rd_seq = ev;
                last_rd = mem_req_laddr;
                pend = mem_req_laddr;
                fill_cnt = 3;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int la, input int off);
        return ADDR_W'(la * LW + off);
    endfunction

    // kind: 0 = miss in both, 1 = main hit, 2 = side-store hit
    task automatic access(input bit wr, input int la, input int off,
                          input logic [31:0] wd, input logic [31:0] exp_d,
                          input int kind, input string req);
        int n = 1;
        int rd0 = rd_count;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = mk(la, off); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9", "ready while busy", 32'(req_ready), 0);
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(rsp_valid == 1'b1, req, "response seen", 32'(rsp_valid), 1);
        check(rsp_rdata == exp_d, req, "data", rsp_rdata, exp_d);
        check(rsp_hit_main == (kind == 1), req, "main status", 32'(rsp_hit_main), 32'(kind == 1));
        check(rsp_hit_victim == (kind == 2), req, "side status", 32'(rsp_hit_victim), 32'(kind == 2));
        if (kind == 1) begin
            check(n == 2, "R2", "main hit latency", 32'(n), 2);
            check(rd_count == rd0, "R2", "no read on hit", 32'(rd_count), 32'(rd0));
        end else if (kind == 2) begin
            check(n == 3, "R5", "swap latency", 32'(n), 3);
        end else begin
            check(rd_count == rd0 + 1, "R3", "one line read", 32'(rd_count), 32'(rd0 + 1));
            check(last_rd == LAW'(la), "R3", "read line address", 32'(last_rd), 32'(la));
        end
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9", "response pulse", 32'(rsp_valid), 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1", "rsp in reset", 32'(rsp_valid), 0);
        check(mem_req_valid == 1'b0, "R1", "mem in reset", 32'(mem_req_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0,
              "R1", "idle after reset", {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    endtask

    task automatic t_cold_and_hit();
        access(0, 'h01, 0, 0, pat('h01, 0), 0, "R3");
        access(0, 'h01, 2, 0, pat('h01, 2), 1, "R3");
    endtask

    task automatic t_conflict_swap();
        access(0, 'h09, 1, 0, pat('h09, 1), 0, "R3");
        access(0, 'h01, 3, 0, pat('h01, 3), 2, "R4");
        access(0, 'h01, 0, 0, pat('h01, 0), 1, "R10");
        access(0, 'h09, 0, 0, pat('h09, 0), 2, "R5");
    endtask

    task automatic t_write_through_swap();
        access(1, 'h01, 1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 2, "R8");
        access(0, 'h01, 1, 0, 32'hDEAD_BEEF, 1, "R8");
    endtask

    task automatic t_lru_and_writeback();
        access(0, 'h11, 0, 0, pat('h11, 0), 0, "R6");
        check(wb_count == 0, "R6", "free slot used", 32'(wb_count), 0);
        access(0, 'h19, 0, 0, pat('h19, 0), 0, "R6");
        check(wb_count == 0, "R7", "clean leaves silently", 32'(wb_count), 0);
        access(0, 'h09, 2, 0, pat('h09, 2), 0, "R6");
        check(wb_count == 1, "R7", "dirty writeback", 32'(wb_count), 1);
        check(last_wb == LAW'('h01), "R7", "writeback address", 32'(last_wb), 32'h01);
        check(last_wb_line[DATA_W +: DATA_W] == 32'hDEAD_BEEF, "R8", "writeback word",
              last_wb_line[DATA_W +: DATA_W], 32'hDEAD_BEEF);
        check(wb_seq < rd_seq, "R7", "writeback before read", 32'(wb_seq), 32'(rd_seq));
        access(0, 'h01, 1, 0, 32'hDEAD_BEEF, 0, "R7");
        access(0, 'h19, 2, 0, pat('h19, 2), 2, "R6");
        access(0, 'h11, 3, 0, pat('h11, 3), 0, "R6");
    endtask

    task automatic t_write_miss();
        access(1, 'h22, 3, 32'h0000_1234, 32'h0000_1234, 0, "R8");
        access(0, 'h22, 3, 0, 32'h0000_1234, 1, "R8");
        access(0, 'h22, 0, 0, pat('h22, 0), 1, "R2");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_cold_and_hit();
        t_conflict_swap();
        t_write_through_swap();
        t_lru_and_writeback();
        t_write_miss();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule